// File: doc/BRIEF.md
# Bus-Cycle Break Comparator

This block watches every bus cycle from the processor and from the DMA engine. It raises a break request to the processor when one cycle matches a condition that software has programmed. The condition has two parts. The first is a 32-bit compare address, written as two 16-bit halves. The second is an 8-bit qualifier that chooses the bus master, the access kind (instruction fetch or data), the direction and, if wanted, the operand size.

On-chip fetches are 32 bits wide and carry two 16-bit instructions. A break programmed on either halfword matches that single wide cycle. The request is then withheld until the processor reaches the instruction boundary where the break belongs. The processor reports its instruction boundaries on a step strobe. With each step it gives the start address of the next instruction and says whether an interrupt can be taken there.

- A fetch break on an accepting boundary is precise: the saved PC is the break address.
- A fetch break on a boundary that cannot accept (a delay slot, or after an interrupt-blocking instruction) lets that instruction run. The break then fires at the next accepting boundary, and that boundary's address is saved.
- A data break is imprecise: it fires at the next accepting boundary after the matching cycle.

The request and the saved PC hold until the processor acknowledges the break.

Top module: `break_watch`

## Requirements
- R1: After reset the compare address and qualifier are zero and `brk_req` and `brk_pc` are zero. With the zero qualifier, no bus cycle raises a break.
- R2: A write with `reg_sel`=00 loads address bits [31:16], `reg_sel`=01 loads bits [15:0], and `reg_sel`=10 loads the qualifier from `reg_wdata[7:0]`.
- R3: Qualifier bits [7:6] select the master (01 CPU, 10 DMA, 11 either), bits [5:4] the access (01 fetch, 10 data, 11 either) and bits [3:2] the direction (01 read, 10 write, 11 either). A 00 in any of these three fields disables matching. For example, 0x54 matches CPU instruction fetch reads and 0x14 matches nothing.
- R4: Qualifier bits [1:0] set the size: 00 ignores size, and any other value must equal `cyc_size` (01 byte, 10 word, 11 long).
- R5: Fetch cycles always count as reads, whatever `cyc_write` says. A qualifier that asks for fetch plus write only (for example 0x58) never raises a break.
- R6: A wide fetch (`cyc_wide`=1) matches when the compare address equals either halfword of the aligned 32-bit word, that is when bits [31:2] are equal. Every other cycle needs all 32 address bits equal.
- R7: After a fetch match, steps whose `cpu_next_pc` differs from the compare address are passed over. A step at the compare address with `cpu_int_ok`=1 raises `brk_req` on the following cycle, with `brk_pc` equal to the compare address.
- R8: After a fetch match, a step at the compare address with `cpu_int_ok`=0 raises nothing. The break is taken at the next step with `cpu_int_ok`=1, and `brk_pc` is that step's `cpu_next_pc`.
- R9: After a data match, the break is taken at the first later step with `cpu_int_ok`=1, and `brk_pc` is that step's `cpu_next_pc`.
- R10: `brk_req` and `brk_pc` stay unchanged until `cpu_ack`. `brk_req` is low on the cycle after the acknowledge. Matching cycles that arrive while a break is pending are ignored.
- R11: A DMA cycle matches only when the master field allows DMA. A CPU cycle matches only when the master field allows the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 00 address high, 01 address low, 10 qualifier |
| reg_wdata | input | 16 | Register write data |
| cyc_valid | input | 1 | A bus cycle is present |
| cyc_dma | input | 1 | 1 = DMA master, 0 = CPU |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write |
| cyc_size | input | 2 | Operand size: 01 byte, 10 word, 11 long |
| cyc_wide | input | 1 | Fetch is 32 bits wide and carries two halfwords |
| cyc_addr | input | 32 | Bus cycle address |
| cpu_step | input | 1 | An instruction boundary is reached |
| cpu_int_ok | input | 1 | An interrupt can be accepted at this boundary |
| cpu_next_pc | input | 32 | Start address of the instruction at this boundary |
| cpu_ack | input | 1 | Processor has taken the break |
| brk_req | output | 1 | Break request |
| brk_pc | output | 32 | PC value to save |

## Verification
The bench first drives a narrow fetch at the break address, followed by steps before and at that address. This separates passing over the earlier instruction from firing precisely. Wide fetches are aimed at the second halfword, and a narrow fetch at the neighbouring halfword, to show that the pairing applies only to wide cycles. A step at the break address with interrupts blocked, followed by an accepting step, shows that the deferred break saves the later boundary's address. Data writes of matching and mismatching size, direction and master test each qualifier field on its own. A fetch flagged as a write under qualifier 0x58 checks that fetches always count as reads.

// File: rtl/brkw_pkg.sv
package brkw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ANY   = 2'd2,
        ST_FIRE  = 2'd3
    } brk_state_e;

    localparam logic [1:0] SEL_ADDR_HI = 2'b00;
    localparam logic [1:0] SEL_ADDR_LO = 2'b01;
    localparam logic [1:0] SEL_QUAL    = 2'b10;

    localparam int QUAL_W = 8;

endpackage

// File: rtl/brkw_regs.sv
module brkw_regs
    import brkw_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [1:0]            sel,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   bar,
    output logic [QUAL_W-1:0]     qual
);
    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [QUAL_W-1:0] ql;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            case (sel)
                SEL_ADDR_HI: r_d.hi = wdata;
                SEL_ADDR_LO: r_d.lo = wdata;
                SEL_QUAL:    r_d.ql = wdata[QUAL_W-1:0];
                default:     r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bar  = {r_q.hi, r_q.lo};
    assign qual = r_q.ql;

endmodule

// File: rtl/brkw_match.sv
module brkw_match
    import brkw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit PAIR_EN  = 1'b1
) (
    input  logic [ADDR_W-1:0] bar,
    input  logic [QUAL_W-1:0] qual,
    input  logic              cyc_valid,
    input  logic              cyc_dma,
    input  logic              cyc_fetch,
    input  logic              cyc_write,
    input  logic [1:0]        cyc_size,
    input  logic              cyc_wide,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              hit,
    output logic              hit_fetch
);
    localparam int PAIR_LSB = 2;

    logic master_ok, access_ok, dir_ok, size_ok, addr_ok, pair_ok, eff_write;

    always_comb begin
        master_ok = cyc_dma ? qual[7] : qual[6];
        access_ok = cyc_fetch ? qual[4] : qual[5];
        // fetches are reads regardless of the write line
        eff_write = cyc_write & ~cyc_fetch;
        dir_ok    = eff_write ? qual[3] : qual[2];
        size_ok   = (qual[1:0] == 2'b00) || (qual[1:0] == cyc_size);
    end

    generate
        if (PAIR_EN) begin : g_pair
            assign pair_ok = cyc_fetch && cyc_wide &&
                             (bar[ADDR_W-1:PAIR_LSB] == cyc_addr[ADDR_W-1:PAIR_LSB]);
        end else begin : g_nopair
            assign pair_ok = 1'b0;
        end
    endgenerate

    assign addr_ok   = pair_ok || (bar == cyc_addr);
    assign hit       = cyc_valid && master_ok && access_ok && dir_ok && size_ok && addr_ok;
    assign hit_fetch = cyc_fetch;

endmodule

// File: rtl/brkw_ctrl.sv
module brkw_ctrl
    import brkw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              hit_fetch,
    input  logic [ADDR_W-1:0] target,
    input  logic              cpu_step,
    input  logic              cpu_int_ok,
    input  logic [ADDR_W-1:0] cpu_next_pc,
    input  logic              cpu_ack,
    output logic              brk_req,
    output logic [ADDR_W-1:0] brk_pc
);
    typedef struct packed {
        brk_state_e        st;
        logic [ADDR_W-1:0] tgt;
        logic [ADDR_W-1:0] pc;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case (c_q.st)
            ST_IDLE: begin
                if (hit) begin
                    c_d.tgt = target;
                    c_d.st  = hit_fetch ? ST_FETCH : ST_ANY;
                end
            end
            ST_FETCH: begin
                if (cpu_step && (cpu_next_pc == c_q.tgt)) begin
                    if (cpu_int_ok) begin
                        c_d.st = ST_FIRE;
                        c_d.pc = c_q.tgt;
                    end else begin
                        // matched instruction runs; take the next accepting boundary
                        c_d.st = ST_ANY;
                    end
                end
            end
            ST_ANY: begin
                if (cpu_step && cpu_int_ok) begin
                    c_d.st = ST_FIRE;
                    c_d.pc = cpu_next_pc;
                end
            end
            ST_FIRE: begin
                if (cpu_ack) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign brk_req = (c_q.st == ST_FIRE);
    assign brk_pc  = c_q.pc;

    // R10: request and PC held until acknowledged
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req && !cpu_ack |=> brk_req && $stable(brk_pc));

    // R10: acknowledge drops the request next cycle
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req && cpu_ack |=> !brk_req);

    // R8: a request only appears after an accepting boundary
    a_r8_accepting: assert property (@(posedge clk) disable iff (!rst_n)
        !brk_req ##1 brk_req |-> $past(cpu_step && cpu_int_ok));

    // R7: a precise fetch break saves the boundary address that matched
    a_r7_precise: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_FETCH) && cpu_step && cpu_int_ok && (cpu_next_pc == c_q.tgt)
        |=> brk_req && (brk_pc == $past(cpu_next_pc)));

endmodule

// File: rtl/break_watch.sv
module break_watch
    import brkw_pkg::*;
#(
    parameter int HALF_W  = 16,
    parameter bit PAIR_EN = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [1:0]            reg_sel,
    input  logic [HALF_W-1:0]     reg_wdata,
    input  logic                  cyc_valid,
    input  logic                  cyc_dma,
    input  logic                  cyc_fetch,
    input  logic                  cyc_write,
    input  logic [1:0]            cyc_size,
    input  logic                  cyc_wide,
    input  logic [2*HALF_W-1:0]   cyc_addr,
    input  logic                  cpu_step,
    input  logic                  cpu_int_ok,
    input  logic [2*HALF_W-1:0]   cpu_next_pc,
    input  logic                  cpu_ack,
    output logic                  brk_req,
    output logic [2*HALF_W-1:0]   brk_pc
);
    localparam int ADDR_W = 2 * HALF_W;

    logic [ADDR_W-1:0] bar;
    logic [QUAL_W-1:0] qual;
    logic              hit, hit_fetch;

    brkw_regs #(.HALF_W(HALF_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .bar   (bar),
        .qual  (qual)
    );

    brkw_match #(.ADDR_W(ADDR_W), .PAIR_EN(PAIR_EN)) u_match (
        .bar       (bar),
        .qual      (qual),
        .cyc_valid (cyc_valid),
        .cyc_dma   (cyc_dma),
        .cyc_fetch (cyc_fetch),
        .cyc_write (cyc_write),
        .cyc_size  (cyc_size),
        .cyc_wide  (cyc_wide),
        .cyc_addr  (cyc_addr),
        .hit       (hit),
        .hit_fetch (hit_fetch)
    );

    brkw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit         (hit),
        .hit_fetch   (hit_fetch),
        .target      (bar),
        .cpu_step    (cpu_step),
        .cpu_int_ok  (cpu_int_ok),
        .cpu_next_pc (cpu_next_pc),
        .cpu_ack     (cpu_ack),
        .brk_req     (brk_req),
        .brk_pc      (brk_pc)
    );

    // R5: a fetch under a write-only direction never matches
    a_r5_fetch_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_fetch && (qual[3:2] == 2'b10) |-> !hit);

    // R3: an empty master, access or direction field blocks every match
    a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (qual[7:6] == 2'b00) || (qual[5:4] == 2'b00) || (qual[3:2] == 2'b00) |-> !hit);

    // R11: a DMA cycle cannot match when the master field excludes DMA
    a_r11_master: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_dma && !qual[7] |-> !hit);

endmodule

// File: tb/break_watch_bench.sv
module break_watch_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [15:0] reg_wdata;
    logic        cyc_valid, cyc_dma, cyc_fetch, cyc_write, cyc_wide;
    logic [1:0]  cyc_size;
    logic [31:0] cyc_addr;
    logic        cpu_step, cpu_int_ok, cpu_ack;
    logic [31:0] cpu_next_pc;
    logic        brk_req;
    logic [31:0] brk_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    break_watch u_break_watch (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .cyc_valid(cyc_valid), .cyc_dma(cyc_dma),
        .cyc_fetch(cyc_fetch), .cyc_write(cyc_write), .cyc_size(cyc_size),
        .cyc_wide(cyc_wide), .cyc_addr(cyc_addr), .cpu_step(cpu_step),
        .cpu_int_ok(cpu_int_ok), .cpu_next_pc(cpu_next_pc), .cpu_ack(cpu_ack),
        .brk_req(brk_req), .brk_pc(brk_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_we = 0; reg_sel = 0; reg_wdata = 0;
        cyc_valid = 0; cyc_dma = 0; cyc_fetch = 0; cyc_write = 0;
        cyc_size = 0; cyc_wide = 0; cyc_addr = 0;
        cpu_step = 0; cpu_int_ok = 0; cpu_next_pc = 0; cpu_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic setup(input logic [31:0] addr, input logic [7:0] q);
        wr(2'b00, addr[31:16]);
        wr(2'b01, addr[15:0]);
        wr(2'b10, {8'h00, q});
    endtask

    task automatic bus(input logic dma, input logic fetch, input logic write,
                       input logic [1:0] size, input logic wide, input logic [31:0] addr);
        cyc_valid = 1; cyc_dma = dma; cyc_fetch = fetch; cyc_write = write;
        cyc_size = size; cyc_wide = wide; cyc_addr = addr;
        @(negedge clk);
        cyc_valid = 0; cyc_dma = 0; cyc_fetch = 0; cyc_write = 0; cyc_wide = 0;
    endtask

    task automatic step(input logic [31:0] pc, input logic ok);
        cpu_step = 1; cpu_next_pc = pc; cpu_int_ok = ok;
        @(negedge clk);
        cpu_step = 0; cpu_int_ok = 0;
    endtask

    task automatic ack();
        cpu_ack = 1;
        @(negedge clk);
        cpu_ack = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 req after reset", {31'b0, brk_req}, 32'd0);
        chk("R1 pc after reset", brk_pc, 32'd0);
        bus(0, 1, 0, 2'b11, 0, 32'h0);
        step(32'h0, 1);
        chk("R1 zero qualifier no break", {31'b0, brk_req}, 32'd0);
    endtask

    task automatic t_precise();
        do_reset();
        setup(32'h0000_0404, 8'h54);
        bus(0, 1, 0, 2'b10, 0, 32'h0000_0404);
        step(32'h0000_0402, 1);
        chk("R7 earlier step passed over", {31'b0, brk_req}, 32'd0);
        step(32'h0000_0404, 1);
        chk("R7 fetch break raised", {31'b0, brk_req}, 32'd1);
        chk("R7 R2 saved pc is break address", brk_pc, 32'h0000_0404);
        bus(0, 1, 0, 2'b10, 0, 32'h0000_0404);
        step(32'h0000_0500, 1);
        chk("R10 held before ack", {31'b0, brk_req}, 32'd1);
        chk("R10 pc stable while pending", brk_pc, 32'h0000_0404);
        ack();
        chk("R10 cleared after ack", {31'b0, brk_req}, 32'd0);
    endtask

    task automatic t_wide();
        do_reset();
        setup(32'h0015_389E, 8'h54);
        bus(0, 1, 0, 2'b11, 1, 32'h0015_389C);
        step(32'h0015_389C, 1);
        chk("R6 first halfword no break", {31'b0, brk_req}, 32'd0);
        step(32'h0015_389E, 1);
        chk("R6 second halfword break", {31'b0, brk_req}, 32'd1);
        chk("R6 pc second halfword", brk_pc, 32'h0015_389E);
        do_reset();
        setup(32'h0015_389E, 8'h54);
        bus(0, 1, 0, 2'b10, 0, 32'h0015_389C);
        step(32'h0015_389E, 1);
        chk("R6 narrow fetch needs exact address", {31'b0, brk_req}, 32'd0);
    endtask

    task automatic t_fetch_write();
        do_reset();
        setup(32'h0015_389C, 8'h58);
        bus(0, 1, 1, 2'b11, 0, 32'h0015_389C);
        step(32'h0015_389C, 1);
        step(32'h0015_389E, 1);
        chk("R5 fetch with write qualifier never fires", {31'b0, brk_req}, 32'd0);
    endtask

    task automatic t_defer();
        do_reset();
        setup(32'h0000_2000, 8'h54);
        bus(0, 1, 0, 2'b10, 0, 32'h0000_2000);
        step(32'h0000_2000, 0);
        chk("R8 blocked boundary no break", {31'b0, brk_req}, 32'd0);
        step(32'h0000_2002, 1);
        chk("R8 deferred break raised", {31'b0, brk_req}, 32'd1);
        chk("R8 deferred pc", brk_pc, 32'h0000_2002);
        ack();
    endtask

    task automatic t_data();
        do_reset();
        setup(32'h0000_8000, 8'h6A);
        bus(0, 0, 1, 2'b01, 0, 32'h0000_8000);
        step(32'h0000_0100, 1);
        chk("R4 size mismatch no break", {31'b0, brk_req}, 32'd0);
        bus(0, 0, 0, 2'b10, 0, 32'h0000_8000);
        step(32'h0000_0100, 1);
        chk("R3 direction mismatch no break", {31'b0, brk_req}, 32'd0);
        bus(1, 0, 1, 2'b10, 0, 32'h0000_8000);
        step(32'h0000_0100, 1);
        chk("R11 DMA excluded by CPU field", {31'b0, brk_req}, 32'd0);
        bus(0, 0, 1, 2'b10, 0, 32'h0000_8000);
        step(32'h0000_0100, 0);
        chk("R9 waits for accepting boundary", {31'b0, brk_req}, 32'd0);
        step(32'h0000_0102, 1);
        chk("R9 data break raised", {31'b0, brk_req}, 32'd1);
        chk("R9 imprecise pc", brk_pc, 32'h0000_0102);
        ack();
    endtask

    task automatic t_dma();
        do_reset();
        setup(32'h0000_8000, 8'hAA);
        bus(0, 0, 1, 2'b10, 0, 32'h0000_8000);
        step(32'h0000_0300, 1);
        chk("R11 CPU excluded by DMA field", {31'b0, brk_req}, 32'd0);
        bus(1, 0, 1, 2'b10, 0, 32'h0000_8000);
        step(32'h0000_0300, 1);
        chk("R11 DMA break raised", {31'b0, brk_req}, 32'd1);
        chk("R11 DMA break pc", brk_pc, 32'h0000_0300);
        ack();
    endtask

    task automatic t_disable();
        do_reset();
        setup(32'h0000_0404, 8'h14);
        bus(0, 1, 0, 2'b10, 0, 32'h0000_0404);
        step(32'h0000_0404, 1);
        chk("R3 empty master field disables", {31'b0, brk_req}, 32'd0);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        t_reset();
        t_precise();
        t_wide();
        t_fetch_write();
        t_defer();
        t_data();
        t_dma();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule